// File: doc/BRIEF.md
# Write Address Burst Splitter

This block takes one contiguous write command (start byte address, byte count, access kind and, for strict kinds, a transfer size) and turns it into a series of write address requests for a 64-bit AXI4 master port. Each request carries an address, a beat count minus one, a beat size code and the incrementing burst code. Requests go out one at a time over a valid/ready handshake. The data and response channels are handled elsewhere.

The splitter keeps every request inside a narrow burst profile. No request carries more than 32 bytes or more than four beats, and none crosses a 32-byte boundary. Beats of one or two bytes, and of four bytes, always travel alone. Only 8-byte beats are grouped into bursts. Normal memory gets the widest naturally aligned beat that the remaining byte count allows. Device, strongly-ordered and exclusive commands never use a beat wider than the size given with the command. When such a command starts on an address that is not aligned to that size, it is refused with an error pulse and no request goes out.

Top module: `wsplit_top`

## Requirements
- R1: Every request carries at most 32 bytes, counted as (aw_len+1) << aw_size, and aw_burst is always 2'b01 (incrementing).
- R2: aw_len never exceeds 3 and aw_size never exceeds 3 (8-byte beats).
- R3: No request crosses a 32-byte boundary: aw_addr[4:0] plus the request's byte count is at most 32.
- R4: A request whose aw_size is 0, 1 or 2 (1, 2 or 4 bytes) always has aw_len equal to 0.
- R5: Each request uses the largest size code s not above the cap where aw_addr is a multiple of 2^s and at least 2^s bytes remain. With s = 3, the beat count is the least of 4, the remaining bytes divided by 8, and the 8-byte slots left before the next 32-byte boundary.
- R6: cmd_kind encodes 2'b00 normal (cap 3), 2'b01 device, 2'b10 exclusive and 2'b11 strongly-ordered. The three strict kinds are capped at cmd_size (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8), so every request of theirs has aw_size no larger than cmd_size.
- R7: A strict command whose address is not a multiple of 2^cmd_size is accepted and then refused. err_o is high for exactly the one cycle after acceptance, and no request and no done_o pulse follow.
- R8: The requests of one command cover the bytes from cmd_addr up to cmd_addr + cmd_bytes exactly once, in ascending address order.
- R9: done_o is high in the cycle the final request of a command is handshaken and in no other request cycle. A command with a zero byte count issues no request, and done_o is high in the cycle after it is accepted.
- R10: cmd_ready is high only while no request is pending. While aw_valid is high and aw_ready is low, aw_valid and the request fields hold their values into the next cycle.
- R11: During and right after reset, cmd_ready is 1 and aw_valid, done_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Splitter idle, command taken on valid and ready |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_bytes | input | CNT_W | Byte count, zero allowed |
| cmd_kind | input | 2 | Access kind code |
| cmd_size | input | 2 | Beat size cap for strict kinds |
| aw_valid | output | 1 | Address request valid |
| aw_ready | input | 1 | Address request accepted |
| aw_addr | output | ADDR_W | Request start address |
| aw_len | output | 8 | Beats minus one |
| aw_size | output | 3 | Beat size code |
| aw_burst | output | 2 | Burst type, always incrementing |
| done_o | output | 1 | Final request of a command handshaken, or zero-length command finished |
| err_o | output | 1 | Strict command refused for misalignment |

## Verification
The bench aims at starts just below a 32-byte boundary. There, a splitter that sized bursts only by the remaining bytes would spill into the next block. It also aims at odd starts and odd byte counts, where a wrong alignment search would issue 8-byte beats at unaligned addresses or lose the tail bytes. Strict commands are driven at misaligned addresses to catch a design that still issues requests or raises done. Zero-length commands and long ready stalls cover a design that would hang, drop the done pulse, or change fields while it waits for a handshake.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
  typedef enum logic [1:0] {
    KIND_NORMAL = 2'b00,
    KIND_DEVICE = 2'b01,
    KIND_EXCL   = 2'b10,
    KIND_STRONG = 2'b11
  } acc_kind_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } split_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/wsplit_align_chk.sv
module wsplit_align_chk #(
  parameter int LO_W = 3,
  parameter int SZ_W = 2
) (
  input  logic [LO_W-1:0] addr_lo,
  input  logic [SZ_W-1:0] size,
  output logic            misaligned
);
  logic [LO_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < LO_W; b++) begin
      if (b < int'(size)) mask[b] = 1'b1;
    end
    misaligned = |(addr_lo & mask);
  end
endmodule

// File: rtl/wsplit_planner.sv
module wsplit_planner #(
  parameter int CNT_W       = 12,
  parameter int BUS_BYTES   = 8,
  parameter int MAX_BEATS   = 4,
  parameter int BOUND_BYTES = 32,
  localparam int MAX_SZ     = $clog2(BUS_BYTES),
  localparam int SZ_W       = $clog2(MAX_SZ + 1),
  localparam int BND_LG     = $clog2(BOUND_BYTES)
) (
  input  logic [BND_LG-1:0] addr_lo,
  input  logic [CNT_W-1:0]  rem,
  input  logic [SZ_W-1:0]   cap,
  output logic [2:0]        sz,
  output logic [7:0]        len,
  output logic [CNT_W-1:0]  nbytes
);
  logic [SZ_W-1:0]  sz_sel;
  logic [CNT_W-1:0] room_beats;
  logic [CNT_W-1:0] avail_beats;
  logic [CNT_W-1:0] beats;

  always_comb begin
    sz_sel = '0;
    for (int s = 0; s <= MAX_SZ; s++) begin
      if ((s <= int'(cap)) &&
          ((addr_lo & BND_LG'((1 << s) - 1)) == '0) &&
          (rem >= CNT_W'(1 << s)))
        sz_sel = SZ_W'(s);
    end
  end

  always_comb begin
    room_beats  = (CNT_W'(BOUND_BYTES) - CNT_W'(addr_lo)) >> MAX_SZ;
    avail_beats = rem >> MAX_SZ;
    beats       = CNT_W'(1);
    if (int'(sz_sel) == MAX_SZ) begin
      beats = CNT_W'(MAX_BEATS);
      if (room_beats < beats)  beats = room_beats;
      if (avail_beats < beats) beats = avail_beats;
    end
    nbytes = beats << sz_sel;
    len    = 8'(beats - CNT_W'(1));
    sz     = 3'(sz_sel);
  end
endmodule

// File: rtl/wsplit_top.sv
module wsplit_top #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 12,
  parameter int BUS_BYTES   = 8,
  parameter int MAX_BEATS   = 4,
  parameter int BOUND_BYTES = 32,
  localparam int MAX_SZ     = $clog2(BUS_BYTES),
  localparam int SZ_W       = $clog2(MAX_SZ + 1),
  localparam int BND_LG     = $clog2(BOUND_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_bytes,
  input  logic [1:0]        cmd_kind,
  input  logic [1:0]        cmd_size,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic [2:0]        aw_size,
  output logic [1:0]        aw_burst,
  output logic              done_o,
  output logic              err_o
);
  import wsplit_pkg::*;

  split_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [SZ_W-1:0]   cap_q, cap_d;
  logic              err_q, zdone_q;

  logic              accept, strict, misaligned, reject, zero_len, hs, last_hs, load_en, step_en;
  logic [CNT_W-1:0]  pl_bytes;
  logic [2:0]        pl_sz;
  logic [7:0]        pl_len;

  wsplit_align_chk #(.LO_W(MAX_SZ), .SZ_W(2)) u_align (
    .addr_lo   (cmd_addr[MAX_SZ-1:0]),
    .size      (cmd_size),
    .misaligned(misaligned)
  );

  wsplit_planner #(
    .CNT_W(CNT_W), .BUS_BYTES(BUS_BYTES), .MAX_BEATS(MAX_BEATS), .BOUND_BYTES(BOUND_BYTES)
  ) u_plan (
    .addr_lo(addr_q[BND_LG-1:0]),
    .rem    (rem_q),
    .cap    (cap_q),
    .sz     (pl_sz),
    .len    (pl_len),
    .nbytes (pl_bytes)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign aw_valid  = (state_q == ST_ISSUE);
  assign aw_addr   = addr_q;
  assign aw_len    = pl_len;
  assign aw_size   = pl_sz;
  assign aw_burst  = BURST_INCR;

  assign accept   = cmd_valid && cmd_ready;
  assign strict   = (acc_kind_e'(cmd_kind) != KIND_NORMAL);
  assign reject   = accept && strict && misaligned;
  assign zero_len = accept && !reject && (cmd_bytes == '0);
  assign hs       = aw_valid && aw_ready;
  assign last_hs  = hs && (rem_q == pl_bytes);
  assign load_en  = accept && !reject && !zero_len;
  assign step_en  = hs;

  assign done_o = last_hs || zdone_q;
  assign err_o  = err_q;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    cap_d   = cap_q;
    if (load_en) begin
      state_d = ST_ISSUE;
      addr_d  = cmd_addr;
      rem_d   = cmd_bytes;
      cap_d   = strict ? SZ_W'(cmd_size) : SZ_W'(MAX_SZ);
    end else if (step_en) begin
      addr_d = addr_q + ADDR_W'(pl_bytes);
      rem_d  = rem_q - pl_bytes;
      if (last_hs) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      cap_q   <= '0;
      err_q   <= 1'b0;
      zdone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_en || step_en) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
        cap_q  <= cap_d;
      end
      err_q   <= reject;
      zdone_q <= zero_len;
    end
  end

  // R1: byte count per request and burst code
  a_r1_max_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (((int'(aw_len) + 1) << aw_size) <= BOUND_BYTES) && (aw_burst == 2'b01));

  // R2: beat count and beat size limits
  a_r2_len_size: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (int'(aw_len) < MAX_BEATS) && (int'(aw_size) <= MAX_SZ));

  // R3: no boundary crossing
  a_r3_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (int'(aw_addr[BND_LG-1:0]) + ((int'(aw_len) + 1) << aw_size)) <= BOUND_BYTES);

  // R4: narrow beats go alone
  a_r4_narrow_single: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && (int'(aw_size) < MAX_SZ)) |-> (aw_len == 8'd0));

  // R6: size aligned and within the cap
  a_r6_aligned_cap: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> ((int'(aw_addr[MAX_SZ-1:0]) % (1 << aw_size)) == 0) && (aw_size <= 3'(cap_q)));

  // R7: refusal issues nothing
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !aw_valid && !done_o);

  // R10: request held while stalled
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> aw_valid && $stable(aw_addr) && $stable(aw_len) && $stable(aw_size));
endmodule

// File: tb/sim_wsplit_top.sv
`timescale 1ns/100ps
module sim_wsplit_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_addr;
  logic [11:0] cmd_bytes;
  logic [1:0]  cmd_kind, cmd_size;
  logic        aw_valid, aw_ready;
  logic [31:0] aw_addr;
  logic [7:0]  aw_len;
  logic [2:0]  aw_size;
  logic [1:0]  aw_burst;
  logic        done_o, err_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  wsplit_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_kind(cmd_kind), .cmd_size(cmd_size),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_size(aw_size), .aw_burst(aw_burst), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  // reference choice of size and beats for one request
  function automatic void model_req(input longint a, input int rem, input int cap,
                                    output int sz, output int beats);
    int room;
    sz = 0;
    for (int s = cap; s >= 0; s--) begin
      if ((a % (1 << s)) == 0 && rem >= (1 << s)) begin
        sz = s;
        break;
      end
    end
    beats = 1;
    if (sz == 3) begin
      beats = rem / 8;
      if (beats > 4) beats = 4;
      room = (32 - int'(a % 32)) / 8;
      if (room < beats) beats = room;
    end
  endfunction

  task automatic run_cmd(input logic [31:0] a, input int nb, input int kind, input int size,
                         input int stall_pct);
    bit     rej;
    longint ma;
    int     mrem, mcap, esz, ebeats, ebytes, covered;
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R10 ready before command", cmd_ready, 1);
    cmd_addr  = a;
    cmd_bytes = 12'(nb);
    cmd_kind  = 2'(kind);
    cmd_size  = 2'(size);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    rej = (kind != 0) && ((a % (1 << size)) != 0);
    if (rej) begin
      chk(err_o === 1'b1, "R7 err pulse", err_o, 1);
      chk(aw_valid === 1'b0 && done_o === 1'b0, "R7 nothing issued", aw_valid, 0);
      @(negedge clk);
      chk(err_o === 1'b0 && aw_valid === 1'b0, "R7 single pulse", err_o, 0);
      return;
    end
    if (nb == 0) begin
      chk(done_o === 1'b1 && aw_valid === 1'b0, "R9 zero length done", done_o, 1);
      @(negedge clk);
      chk(done_o === 1'b0, "R9 zero length pulse ends", done_o, 0);
      return;
    end
    ma = a; mrem = nb; mcap = (kind == 0) ? 3 : size; covered = 0;
    while (mrem > 0) begin
      model_req(ma, mrem, mcap, esz, ebeats);
      ebytes = ebeats << esz;
      aw_ready = (($urandom % 100) >= stall_pct);
      #1;
      chk(aw_valid === 1'b1, "R10 request pending", aw_valid, 1);
      chk(aw_addr === 32'(ma), "R8 request address", aw_addr, ma);
      chk(int'(aw_size) == esz, "R5 size choice", aw_size, esz);
      chk(int'(aw_len) == ebeats - 1, "R5 beat count", aw_len, ebeats - 1);
      chk(aw_burst === 2'b01 && ebytes <= 32, "R1 burst and bytes", aw_burst, 1);
      chk(aw_len <= 8'd3 && aw_size <= 3'd3, "R2 limits", aw_len, 3);
      chk(int'(aw_addr % 32) + ((int'(aw_len) + 1) << aw_size) <= 32, "R3 no crossing",
          aw_addr % 32, 0);
      if (aw_size < 3'd3) chk(aw_len == 8'd0, "R4 narrow single", aw_len, 0);
      chk(int'(aw_size) <= mcap, "R6 size cap", aw_size, mcap);
      if (aw_ready) begin
        chk(done_o === (mrem == ebytes), "R9 done on final", done_o, mrem == ebytes);
        ma += ebytes; mrem -= ebytes; covered += ebytes;
      end else begin
        chk(done_o === 1'b0, "R9 no done while stalled", done_o, 0);
      end
      @(negedge clk);
    end
    aw_ready = 1'b0;
    chk(covered == nb, "R8 bytes covered", covered, nb);
    chk(aw_valid === 1'b0 && cmd_ready === 1'b1, "R10 idle after command", aw_valid, 0);
  endtask

  initial begin
    int k;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cmd_valid = 1'b0; aw_ready = 1'b0;
    cmd_addr = '0; cmd_bytes = '0; cmd_kind = '0; cmd_size = '0;
    #1;
    chk(cmd_ready === 1'b1 && aw_valid === 1'b0, "R11 reset ready", cmd_ready, 1);
    chk(done_o === 1'b0 && err_o === 1'b0, "R11 reset flags", done_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready === 1'b1 && aw_valid === 1'b0 && done_o === 1'b0 && err_o === 1'b0,
        "R11 after reset", aw_valid, 0);

    run_cmd(32'h1000, 32, 0, 0, 0);    // R5 one full burst
    run_cmd(32'h1003, 13, 0, 0, 30);   // R5 odd start: 1, 4, 8
    run_cmd(32'h0018, 64, 0, 0, 50);   // R3 boundary cut: 8, 32, 24
    run_cmd(32'h2002, 16, 1, 2, 0);    // R7 device misaligned
    run_cmd(32'h2003, 4, 2, 1, 0);     // R7 exclusive misaligned
    run_cmd(32'h3000, 6, 2, 1, 20);    // R6 exclusive halfwords
    run_cmd(32'h4000, 24, 3, 3, 0);    // R6 strongly-ordered 8-byte
    run_cmd(32'h5004, 0, 0, 0, 0);     // R9 zero length
    run_cmd(32'h6007, 1, 0, 0, 0);     // R4 single byte
    run_cmd(32'h7000, 40, 1, 2, 60);   // R4 device words, long stalls

    for (int i = 0; i < 300; i++) begin
      k = int'($urandom % 4);
      run_cmd(32'h8000 + ($urandom % 256), int'($urandom % 100), k, int'($urandom % 4),
              int'($urandom % 70));
    end
    report();
  end
endmodule